// File: doc/BRIEF.md
# Multiplexed-Address Strobed Bit Memory

A single-bit-wide read/write store of 4096 locations held in flip-flops, reached through a strobed interface with a shared address bus. Six address pins carry two values one after the other. The row half is taken when the active-low row strobe falls, and the column half is taken when the active-low column strobe falls. The full location is the row value in the upper bits followed by the column value in the lower bits. Storage is a 64 x 64 bit array.

The strobes, the write enable and the data input are sampled on the module clock. A strobe edge is recognised when two consecutive clock samples differ. A column-strobe fall that opens an access while the row is open captures the column, the write enable and the data-in bit. On the next clock edge the access runs from the latched row and column. A write stores the bit. A read loads the stored bit into an output register, and that register is shown only while both strobes remain low. A rise of the row strobe ends the access cycle and closes the row.

Top module: `strobed_bit_mem`

## Requirements
- R1: While `rst` is high, and on the first cycle after it drops, `dout` and `dout_valid` are 0 and no row is open. The strobe history resets to the high (idle) level.
- R2: A row-strobe fall is a clock edge where `ras_n` is sampled 0 after being sampled 1 at the previous edge. At that edge `addr` is stored as the row and the row becomes open.
- R3: An access is a column-strobe fall (`cas_n` sampled 1 then 0) at an edge where `ras_n` is sampled 0 and the row was already open before that edge. At that edge `addr` is stored as the column. The location used is index = row * 2^ADDR_W + column, so the row occupies the high bits.
- R4: If `we_n` is 0 at the access edge, the `din` value sampled at that edge is written to the location on the following edge. `dout_valid` stays 0 for a write.
- R5: If `we_n` is 1 at the access edge, the stored bit appears on `dout` with `dout_valid` = 1 after the following edge. This happens only if both strobes are still sampled low at that following edge.
- R6: At any edge where `ras_n` or `cas_n` is sampled 1 (and no read completes), `dout_valid` and `dout` become 0. Outside `dout_valid`, `dout` is always 0.
- R7: A column-strobe fall while the row is not open is ignored. This includes a fall detected at the same edge as the row-strobe fall. No write takes place and `dout_valid` stays 0.
- R8: A row-strobe rise (`ras_n` sampled 0 then 1) closes the row. A later column-strobe fall is ignored until a new row-strobe fall.
- R9: `addr`, `din` and `we_n` matter only at the edges named in R2 to R4. Changes at any other time do not alter the row, the column or the stored data.
- R10: While the row strobe stays low, repeated column-strobe cycles each perform an access in the same latched row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable, taken at the column-strobe fall |
| addr | input | ADDR_W | Shared row/column address pins |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when not valid |
| dout_valid | output | 1 | High while a read result is being shown |

## Verification
The bench builds the block with ADDR_W = 4, a 16 x 16 array of 256 cells. With that size every location can be written and read back in a few thousand cycles. An asymmetric data pattern makes a swapped row/column order or a misplaced bit show up. The small array also leaves room for directed sequences on strobe ordering: a simultaneous row and column fall, a column fall after the row closes, a strobe rising one cycle after the access edge, and address or data wiggling between edges. A behavioural model compares both outputs on every clock.

// File: rtl/mam_pkg.sv
package mam_pkg;

    // Kind of access pending for the cycle after a column-strobe fall
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Strobe edge events seen at one clock edge
    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
    } strobe_evt_t;

    function automatic strobe_evt_t find_edges(
        input logic ras_prev, input logic ras_now,
        input logic cas_prev, input logic cas_now);
        strobe_evt_t e;
        e.ras_fall = ras_prev & ~ras_now;
        e.ras_rise = ~ras_prev & ras_now;
        e.cas_fall = cas_prev & ~cas_now;
        return e;
    endfunction

    function automatic acc_kind_e decide_access(
        input logic row_open, input logic ras_low,
        input logic cas_fall, input logic we_n);
        if (!(row_open && ras_low && cas_fall))
            return ACC_NONE;
        return we_n ? ACC_READ : ACC_WRITE;
    endfunction

endpackage

// File: rtl/mam_strobe_sync.sv
module mam_strobe_sync
    import mam_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ras_n,
    input  logic        cas_n,
    output strobe_evt_t evt
);
    logic ras_q;
    logic cas_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    assign evt = find_edges(ras_q, ras_n, cas_q, cas_n);

endmodule

// File: rtl/mam_addr_ctrl.sv
module mam_addr_ctrl
    import mam_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int IDX_W = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_evt_t       evt,
    input  logic              ras_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output acc_kind_e         pend,
    output logic              pend_din,
    output logic [IDX_W-1:0]  idx,
    output logic              row_open
);
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    acc_kind_e         kind;

    assign kind = decide_access(row_open, ~ras_n, evt.cas_fall, we_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            col_q    <= '0;
            row_open <= 1'b0;
            pend     <= ACC_NONE;
            pend_din <= 1'b0;
        end else begin
            pend <= kind;
            if (kind != ACC_NONE) begin
                col_q    <= addr;
                pend_din <= din;
            end
            if (evt.ras_fall) begin
                row_q    <= addr;
                row_open <= 1'b1;
            end else if (evt.ras_rise) begin
                row_open <= 1'b0;
            end
        end
    end

    assign idx = {row_q, col_q};

    // R2
    row_capture_chk: assert property (@(posedge clk) disable iff (rst)
        evt.ras_fall |=> (row_open && idx[IDX_W-1:ADDR_W] == $past(addr)));

    // R8
    row_close_chk: assert property (@(posedge clk) disable iff (rst)
        evt.ras_rise |=> !row_open);

    // R7
    closed_row_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.cas_fall && !row_open) |=> (pend == ACC_NONE));

    // R3
    col_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.cas_fall && row_open && !ras_n) |=> (idx[ADDR_W-1:0] == $past(addr)));

endmodule

// File: rtl/mam_bit_array.sv
module mam_bit_array #(
    parameter int ADDR_W = 6,
    localparam int ROWS  = 1 << ADDR_W,
    localparam int COLS  = 1 << ADDR_W,
    localparam int DEPTH = ROWS * COLS,
    localparam int IDX_W = 2 * ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic             din,
    output logic             rd_bit
);
    logic [DEPTH-1:0]  flat;
    logic [ADDR_W-1:0] sel_row;
    logic [ADDR_W-1:0] sel_col;

    assign sel_row = idx[IDX_W-1:ADDR_W];
    assign sel_col = idx[ADDR_W-1:0];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] line_q;
        always_ff @(posedge clk) begin
            if (wr_en && sel_row == ADDR_W'(r))
                line_q[sel_col] <= din;
        end
        assign flat[r*COLS +: COLS] = line_q;
    end

    assign rd_bit = flat[idx];

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flat[$past(idx)] == $past(din)));

endmodule

// File: rtl/strobed_bit_mem.sv
module strobed_bit_mem
    import mam_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int IDX_W = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_valid
);
    strobe_evt_t      evt;
    acc_kind_e        pend;
    logic             pend_din;
    logic [IDX_W-1:0] idx;
    logic             row_open;
    logic             rd_bit;
    logic             hold_q;
    logic             data_q;

    mam_strobe_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .evt   (evt)
    );

    mam_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .ras_n    (ras_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (din),
        .pend     (pend),
        .pend_din (pend_din),
        .idx      (idx),
        .row_open (row_open)
    );

    mam_bit_array #(.ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (pend == ACC_WRITE),
        .idx    (idx),
        .din    (pend_din),
        .rd_bit (rd_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            data_q <= 1'b0;
        end else if (pend == ACC_READ && !ras_n && !cas_n) begin
            hold_q <= 1'b1;
            data_q <= rd_bit;
        end else if (ras_n || cas_n) begin
            hold_q <= 1'b0;
            data_q <= 1'b0;
        end
    end

    assign dout       = data_q;
    assign dout_valid = hold_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!dout_valid && !dout && !row_open));

    // R5
    read_shows_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == ACC_READ && !ras_n && !cas_n) |=> (dout_valid && dout == $past(rd_bit)));

    // R6
    strobe_high_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_n || cas_n) |=> !dout_valid);

    // R6
    dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> !dout);

endmodule

// File: tb/strobed_bit_mem_bench.sv
`timescale 1ns/1ps
module strobed_bit_mem_bench;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << (2 * AW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic          dout;
    logic          dout_valid;

    int    tests = 0;
    int    fails = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    strobed_bit_mem #(.ADDR_W(AW)) u_strobed_bit_mem (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid)
    );

    // Behavioural reference model
    logic          m_mem [DEPTH];
    logic          m_open, m_pr, m_pc, m_ev, m_ed;
    logic [AW-1:0] m_row;
    int            m_pidx;
    logic          m_pw, m_prd, m_pdin;

    always @(posedge clk) begin
        if (rst) begin
            m_open = 1'b0; m_pr = 1'b1; m_pc = 1'b1;
            m_ev = 1'b0; m_ed = 1'b0; m_pw = 1'b0; m_prd = 1'b0;
            m_row = '0;
        end else begin
            logic cf, acc;
            if (m_pw) m_mem[m_pidx] = m_pdin;
            if (m_prd && !ras_n && !cas_n) begin
                m_ev = 1'b1; m_ed = m_mem[m_pidx];
            end else if (ras_n || cas_n) begin
                m_ev = 1'b0; m_ed = 1'b0;
            end
            cf  = m_pc && !cas_n;
            acc = cf && m_open && !ras_n;
            m_pw  = acc && !we_n;
            m_prd = acc && we_n;
            if (acc) begin
                m_pidx = int'(m_row) * (1 << AW) + int'(addr);
                m_pdin = din;
            end
            if (m_pr && !ras_n) begin
                m_row = addr; m_open = 1'b1;
            end else if (!m_pr && ras_n) begin
                m_open = 1'b0;
            end
            m_pr = ras_n; m_pc = cas_n;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (dout !== m_ed || dout_valid !== m_ev) begin
                fails++;
                $display("FAIL %s per-cycle: dout/valid act=%b%b exp=%b%b at %0t",
                         cur_req, dout, dout_valid, m_ed, m_ev, $time);
            end
        end
    end

    function automatic logic pat(input int r, input int c);
        int i = r * (1 << AW) + c;
        return logic'(((i * 5) ^ (i >> 3) ^ r) & 1);
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic ras_down(input logic [AW-1:0] r);
        addr = r; ras_n = 1'b0; @(negedge clk);
    endtask

    task automatic ras_up();
        ras_n = 1'b1; @(negedge clk);
    endtask

    // Write with address and data scrambled after the access edge (R9)
    task automatic cas_write(input logic [AW-1:0] c, input logic b, input string tag);
        addr = c; din = b; we_n = 1'b0; cas_n = 1'b0; @(negedge clk);
        addr = ~c; din = ~b; we_n = 1'b1; @(negedge clk);
        chk(tag, {dout_valid, dout}, 2'b00);
        cas_n = 1'b1; @(negedge clk);
    endtask

    task automatic cas_read(input logic [AW-1:0] c, input logic e, input string tag);
        addr = c; we_n = 1'b1; cas_n = 1'b0; @(negedge clk);
        addr = ~c; @(negedge clk);
        chk(tag, {dout_valid, dout}, {1'b1, e});
        cas_n = 1'b1; @(negedge clk);
        chk({tag, " R6 drop"}, {dout_valid, dout}, 2'b00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R1";
        chk("R1 in reset", {dout_valid, dout}, 2'b00);
        rst = 1'b0; @(negedge clk);
        chk("R1 after reset", {dout_valid, dout}, 2'b00);

        // R4 R3 R10: fill every cell, one row open per row
        cur_req = "R4";
        for (int r = 0; r < (1 << AW); r++) begin
            ras_down(AW'(r));
            for (int c = 0; c < (1 << AW); c++)
                cas_write(AW'(c), pat(r, c), "R4 fill");
            ras_up();
        end

        // R5 R2 R3 R10: read every cell back
        cur_req = "R5";
        for (int r = 0; r < (1 << AW); r++) begin
            ras_down(AW'(r));
            for (int c = 0; c < (1 << AW); c++)
                cas_read(AW'(c), pat(r, c), "R5 R3 readback");
            ras_up();
        end

        // R6: row strobe rises one cycle after access edge cancels the read
        cur_req = "R6";
        ras_down(4'd2);
        addr = 4'd7; we_n = 1'b1; cas_n = 1'b0; @(negedge clk);
        ras_n = 1'b1; @(negedge clk);
        chk("R6 cancelled read", {dout_valid, dout}, 2'b00);
        cas_n = 1'b1; @(negedge clk);
        // R6: valid read, then row strobe rises while column strobe low
        ras_down(4'd2);
        addr = 4'd7; cas_n = 1'b0; @(negedge clk); @(negedge clk);
        chk("R6 valid before rise", {dout_valid, dout}, {1'b1, pat(2, 7)});
        ras_n = 1'b1; @(negedge clk);
        chk("R6 drop on ras rise", {dout_valid, dout}, 2'b00);
        cas_n = 1'b1; @(negedge clk);

        // R7: column fall with row strobe high
        cur_req = "R7";
        addr = 4'd5; din = ~pat(3, 5); we_n = 1'b0; cas_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R7 no access ras high", {dout_valid, dout}, 2'b00);
        cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
        ras_down(4'd3);
        cas_read(4'd5, pat(3, 5), "R7 cell kept");
        ras_up();
        // R7: both strobes fall at the same edge
        addr = 4'd3; din = ~pat(3, 3); we_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R7 simultaneous fall ignored", {dout_valid, dout}, 2'b00);
        cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
        cas_read(4'd3, pat(3, 3), "R7 R10 same row reuse");
        ras_up();

        // R8: column access after row closes is ignored
        cur_req = "R8";
        ras_down(4'd9);
        ras_up();
        cas_write(4'd4, ~pat(9, 4), "R8 write after close");
        ras_down(4'd9);
        cas_read(4'd4, pat(9, 4), "R8 cell kept");
        ras_up();

        // R9: address moves between row fall and column fall
        cur_req = "R9";
        ras_down(4'd6);
        addr = 4'd11; din = 1'b1; we_n = 1'b0; @(negedge clk);
        we_n = 1'b1; @(negedge clk);
        cas_read(4'd1, pat(6, 1), "R9 row held");
        cas_write(4'd1, ~pat(6, 1), "R9 overwrite");
        cas_read(4'd1, ~pat(6, 1), "R9 R4 overwrite visible");
        ras_up();
        ras_down(4'd11);
        cas_read(4'd1, pat(11, 1), "R9 neighbour untouched");
        ras_up();

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule